// File: doc/BRIEF.md
# PCI-X Endpoint Status Register

This block holds the 32-bit status word that a PCI-X endpoint function returns to configuration reads. Most of the word is read-only, and its fields come from three sources.

The bus number and device number are snooped from the address/data lines whenever a Type 0 configuration write targets the function. The 64-bit and 133 MHz capability bits and the designed maximum memory read byte count come from strap bits loaded out of EEPROM. Two sticky flags record split-completion errors, and software clears them by writing ones.

The surrounding configuration logic decodes accesses. It supplies a one-cycle strobe and the captured address/data value for each Type 0 configuration write, and a write enable with data for writes to this register. The EEPROM loader gives a valid pulse with the strap bits. The transaction engine gives one-cycle event pulses. The read value is always present on `sts_rdata`.

Top module: `pcix_status_reg`

## Requirements
- R1: After reset the read value is 32'h0043FFF8. In that value the device number is 5'h1F, the bus number is 8'hFF, the 64-bit bit and the 133 MHz bit are 1, the maximum read field is 2, and both flags are 0.
- R2: A cycle with `cfg_wr_t0` high loads the device number (bits 7:3) from `cfg_ad[15:11]` and the bus number (bits 15:8) from `cfg_ad[7:0]`. The new values read back in the next cycle. Without the strobe, both fields hold their value.
- R3: Bits 2:0 (function number), bit 20 (complexity, 0 = simple device) and bits 31:23 always read 0.
- R4: On the first `ee_valid` pulse after reset, bit 16 takes `ee_is64`, bit 17 takes `ee_fast133`, and bits 22:21 take 3 if `ee_max_read` is 1 or 2 if it is 0. The field codes are 0=512, 1=1024, 2=2048 and 3=4096 bytes.
- R5: Strap inputs have no effect before the first `ee_valid` pulse. Later `ee_valid` pulses are also ignored.
- R6: A pulse on `ev_split_discard` sets bit 18 in the next cycle. The bit stays set until it is cleared.
- R7: A pulse on `ev_unexp_split` sets bit 19 in the next cycle. The bit stays set until it is cleared.
- R8: A register write with data bit 18 or bit 19 at 1 clears that flag. Data bits at 0 leave the flags unchanged. Register writes never change any other bit.
- R9: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_t0 | input | 1 | One-cycle strobe for a Type 0 configuration write |
| cfg_ad | input | 16 | Address/data value captured with the strobe |
| sts_wr_en | input | 1 | Write to this status register |
| sts_wr_data | input | 32 | Write data (ones clear flags) |
| ev_split_discard | input | 1 | Split completion discarded event pulse |
| ev_unexp_split | input | 1 | Unexpected split completion event pulse |
| ee_valid | input | 1 | EEPROM strap values valid pulse |
| ee_is64 | input | 1 | Strap: 64-bit device |
| ee_fast133 | input | 1 | Strap: 133 MHz capable |
| ee_max_read | input | 1 | Strap: 1 selects 4 KB, 0 selects 2 KB maximum read |
| sts_rdata | output | 32 | Status read value |

## Verification
The bench pits an event against a clearing write on the same flag in the same cycle. A design that gives the clear priority would lose the event and read 0.

It writes all-ones and all-zeros data to the register. A design that gates the clear with the wrong bits, or that lets writes reach read-only fields, would change the bus, device or capability bits.

It changes the strap inputs before the first valid pulse and after it, and it sends a second pulse with different straps. A design that samples continuously, or on every pulse, would show the wrong capability bits.

Random configuration writes check that the snooped fields come from the right address/data bits and appear exactly one cycle after the strobe.

// File: rtl/pcxs_pkg.sv
package pcxs_pkg;

    localparam int unsigned STS_W     = 32;
    localparam int unsigned FUNC_LSB  = 0;
    localparam int unsigned DEV_LSB   = 3;
    localparam int unsigned BUS_LSB   = 8;
    localparam int unsigned B64_POS   = 16;
    localparam int unsigned F133_POS  = 17;
    localparam int unsigned FLAG_LSB  = 18;
    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned CPLX_POS  = 20;
    localparam int unsigned MRD_LSB   = 21;

    typedef enum logic [1:0] {
        MRD_512  = 2'd0,
        MRD_1K   = 2'd1,
        MRD_2K   = 2'd2,
        MRD_4K   = 2'd3
    } mrd_code_e;

    typedef struct packed {
        logic      is64;
        logic      fast133;
        mrd_code_e mrd;
    } strap_t;

    localparam strap_t STRAP_RST = '{is64: 1'b1, fast133: 1'b1, mrd: MRD_2K};

    function automatic mrd_code_e mrd_from_strap(input logic max_read);
        return max_read ? MRD_4K : MRD_2K;
    endfunction

endpackage

// File: rtl/pcxs_id_snoop.sv
module pcxs_id_snoop #(
    parameter int unsigned AD_W    = 16,
    parameter int unsigned DEV_W   = 5,
    parameter int unsigned BUS_W   = 8,
    parameter int unsigned DEV_SRC = 11,
    parameter int unsigned BUS_SRC = 0,
    parameter logic [DEV_W-1:0] DEV_RST = '1,
    parameter logic [BUS_W-1:0] BUS_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [AD_W-1:0]  ad,
    output logic [DEV_W-1:0] dev_o,
    output logic [BUS_W-1:0] bus_o
);
    localparam int unsigned DEV_TOP = DEV_SRC + DEV_W - 1;
    localparam int unsigned BUS_TOP = BUS_SRC + BUS_W - 1;

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [BUS_W-1:0] bus;
    } id_t;

    id_t id_d, id_q;

    always_comb begin
        id_d = id_q;
        if (cap_en) begin
            id_d.dev = ad[DEV_TOP:DEV_SRC];
            id_d.bus = ad[BUS_TOP:BUS_SRC];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q.dev <= DEV_RST;
            id_q.bus <= BUS_RST;
        end else begin
            id_q <= id_d;
        end
    end

    assign dev_o = id_q.dev;
    assign bus_o = id_q.bus;

    logic unused_ad;
    assign unused_ad = ^ad;
endmodule

// File: rtl/pcxs_strap_latch.sv
module pcxs_strap_latch
    import pcxs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ee_valid,
    input  logic   ee_is64,
    input  logic   ee_fast133,
    input  logic   ee_max_read,
    output strap_t strap_o
);
    typedef struct packed {
        logic   done;
        strap_t val;
    } latch_t;

    latch_t lt_d, lt_q;

    always_comb begin
        lt_d = lt_q;
        if (ee_valid && !lt_q.done) begin
            lt_d.done        = 1'b1;
            lt_d.val.is64    = ee_is64;
            lt_d.val.fast133 = ee_fast133;
            lt_d.val.mrd     = mrd_from_strap(ee_max_read);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lt_q.done <= 1'b0;
            lt_q.val  <= STRAP_RST;
        end else begin
            lt_q <= lt_d;
        end
    end

    assign strap_o = lt_q.val;
endmodule

// File: rtl/pcxs_sticky_bit.sv
module pcxs_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign q_o = flag_q;
endmodule

// File: rtl/pcix_status_reg.sv
module pcix_status_reg
    import pcxs_pkg::*;
#(
    parameter int unsigned AD_W  = 16,
    parameter int unsigned DEV_W = 5,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_t0,
    input  logic [AD_W-1:0]  cfg_ad,
    input  logic             sts_wr_en,
    input  logic [STS_W-1:0] sts_wr_data,
    input  logic             ev_split_discard,
    input  logic             ev_unexp_split,
    input  logic             ee_valid,
    input  logic             ee_is64,
    input  logic             ee_fast133,
    input  logic             ee_max_read,
    output logic [STS_W-1:0] sts_rdata
);
    localparam int unsigned DEV_TOP  = DEV_LSB + DEV_W - 1;
    localparam int unsigned BUS_TOP  = BUS_LSB + BUS_W - 1;
    localparam int unsigned FLAG_TOP = FLAG_LSB + NUM_FLAGS - 1;

    logic [DEV_W-1:0]     dev_num;
    logic [BUS_W-1:0]     bus_num;
    strap_t               strap;
    logic [NUM_FLAGS-1:0] ev_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flag_vec;

    pcxs_id_snoop #(
        .AD_W   (AD_W),
        .DEV_W  (DEV_W),
        .BUS_W  (BUS_W),
        .DEV_SRC(11),
        .BUS_SRC(0)
    ) u_snoop (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_en(cfg_wr_t0),
        .ad    (cfg_ad),
        .dev_o (dev_num),
        .bus_o (bus_num)
    );

    pcxs_strap_latch u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .ee_valid   (ee_valid),
        .ee_is64    (ee_is64),
        .ee_fast133 (ee_fast133),
        .ee_max_read(ee_max_read),
        .strap_o    (strap)
    );

    assign ev_vec  = {ev_unexp_split, ev_split_discard};
    assign clr_vec = sts_wr_en ? sts_wr_data[FLAG_TOP:FLAG_LSB] : '0;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        pcxs_sticky_bit u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(ev_vec[g]),
            .clr_i(clr_vec[g]),
            .q_o  (flag_vec[g])
        );
    end

    always_comb begin
        sts_rdata                      = '0;
        sts_rdata[DEV_TOP:DEV_LSB]     = dev_num;
        sts_rdata[BUS_TOP:BUS_LSB]     = bus_num;
        sts_rdata[B64_POS]             = strap.is64;
        sts_rdata[F133_POS]            = strap.fast133;
        sts_rdata[FLAG_TOP:FLAG_LSB]   = flag_vec;
        sts_rdata[CPLX_POS]            = 1'b0;
        sts_rdata[MRD_LSB+1:MRD_LSB]   = strap.mrd;
    end

    logic unused_wdata;
    assign unused_wdata = ^sts_wr_data;
endmodule

// File: rtl/pcix_status_chk.sv
module pcix_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_t0,
    input logic [15:0] cfg_ad,
    input logic        sts_wr_en,
    input logic [31:0] sts_wr_data,
    input logic        ev_split_discard,
    input logic        ev_unexp_split,
    input logic        ee_valid,
    input logic        ee_is64,
    input logic        ee_fast133,
    input logic        ee_max_read,
    input logic [31:0] sts_rdata
);
    AST_BUS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_t0 |=> sts_rdata[15:8] == $past(cfg_ad[7:0])); // R2
    AST_DEV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_t0 |=> sts_rdata[7:3] == $past(cfg_ad[15:11])); // R2
    AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_t0 |=> $stable(sts_rdata[15:3])); // R2
    AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rdata[31:23] == '0 && !sts_rdata[20] && sts_rdata[2:0] == '0); // R3
    AST_MRD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rdata[22]); // R4
    AST_DISCARD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_split_discard |=> sts_rdata[18]); // R6
    AST_UNEXP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_unexp_split |=> sts_rdata[19]); // R7
    AST_DISCARD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr_en && sts_wr_data[18] && !ev_split_discard |=> !sts_rdata[18]); // R8
    AST_UNEXP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr_en && sts_wr_data[19] && !ev_unexp_split |=> !sts_rdata[19]); // R8
    AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_valid |=> $stable(sts_rdata[22:16] & 7'b1100011)); // R5
endmodule

bind pcix_status_reg pcix_status_chk u_chk (.*);

// File: tb/pcix_status_reg_bench.sv
module pcix_status_reg_bench;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_t0 = 1'b0;
    logic [15:0] cfg_ad = '0;
    logic        sts_wr_en = 1'b0;
    logic [31:0] sts_wr_data = '0;
    logic        ev_split_discard = 1'b0;
    logic        ev_unexp_split = 1'b0;
    logic        ee_valid = 1'b0;
    logic        ee_is64 = 1'b0;
    logic        ee_fast133 = 1'b0;
    logic        ee_max_read = 1'b0;
    logic [31:0] sts_rdata;

    int total = 0;
    int bad = 0;

    logic [4:0] m_dev;
    logic [7:0] m_bus;
    logic       m_b64, m_f133, m_mr, m_done, m_f18, m_f19;

    always #(CLK_PER/2) clk = ~clk;

    pcix_status_reg u_pcix_status_reg (
        .clk(clk), .rst_n(rst_n), .cfg_wr_t0(cfg_wr_t0), .cfg_ad(cfg_ad),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
        .ev_split_discard(ev_split_discard), .ev_unexp_split(ev_unexp_split),
        .ee_valid(ee_valid), .ee_is64(ee_is64), .ee_fast133(ee_fast133),
        .ee_max_read(ee_max_read), .sts_rdata(sts_rdata)
    );

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[7:3]   = m_dev;
        w[15:8]  = m_bus;
        w[16]    = m_b64;
        w[17]    = m_f133;
        w[18]    = m_f18;
        w[19]    = m_f19;
        w[22:21] = m_mr ? 2'd3 : 2'd2;
        return w;
    endfunction

    task automatic model_reset();
        m_dev = 5'h1F; m_bus = 8'hFF; m_b64 = 1'b1; m_f133 = 1'b1;
        m_mr = 1'b0; m_done = 1'b0; m_f18 = 1'b0; m_f19 = 1'b0;
    endtask

    task automatic model_step();
        if (cfg_wr_t0) begin
            m_dev = cfg_ad[15:11];
            m_bus = cfg_ad[7:0];
        end
        if (ee_valid && !m_done) begin
            m_done = 1'b1; m_b64 = ee_is64; m_f133 = ee_fast133; m_mr = ee_max_read;
        end
        if (sts_wr_en && sts_wr_data[18]) m_f18 = 1'b0;
        if (sts_wr_en && sts_wr_data[19]) m_f19 = 1'b0;
        if (ev_split_discard) m_f18 = 1'b1;
        if (ev_unexp_split)   m_f19 = 1'b1;
    endtask

    task automatic check(input string tag, input logic [31:0] mask);
        logic [31:0] e = exp_word();
        total++;
        if ((sts_rdata & mask) !== (e & mask)) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (mask %h)", tag, sts_rdata & mask, e & mask, mask);
        end
    endtask

    task automatic check_all();
        check("R2 ids", 32'h0000_FFF8);
        check("R3 zeros", 32'hFF90_0007);
        check("R4/R5 straps", 32'h0063_0000);
        check("R6 discard flag", 32'h0004_0000);
        check("R7 unexpected flag", 32'h0008_0000);
    endtask

    task automatic idle_inputs();
        cfg_wr_t0 = 1'b0; sts_wr_en = 1'b0; sts_wr_data = '0;
        ev_split_discard = 1'b0; ev_unexp_split = 1'b0; ee_valid = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        model_step();
        idle_inputs();
    endtask

    initial begin : watchdog
        #(CLK_PER * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset word", 32'hFFFF_FFFF);
        total++;
        if (sts_rdata !== 32'h0043FFF8) begin
            bad++;
            $display("FAIL R1: actual=%h expected=%h", sts_rdata, 32'h0043FFF8);
        end

        // R5: straps move without a valid pulse
        ee_is64 = 1'b0; ee_fast133 = 1'b0; ee_max_read = 1'b1;
        step(); step();
        check("R5 straps before valid", 32'h0063_0000);

        // R4: first valid pulse samples
        ee_valid = 1'b1;
        step();
        check("R4 first valid", 32'h0063_0000);
        // R5: second pulse with other straps ignored
        ee_is64 = 1'b1; ee_fast133 = 1'b1; ee_max_read = 1'b0; ee_valid = 1'b1;
        step();
        check("R5 second valid ignored", 32'h0063_0000);

        // R2: configuration write capture, visible the next cycle
        cfg_wr_t0 = 1'b1; cfg_ad = 16'hA35C;
        step();
        check("R2 capture", 32'h0000_FFF8);
        cfg_ad = 16'h0000;
        step();
        check("R2 hold without strobe", 32'h0000_FFF8);

        // R6 / R7: sticky set
        ev_split_discard = 1'b1;
        step(); step();
        check("R6 sticky", 32'h0004_0000);
        ev_unexp_split = 1'b1;
        step(); step();
        check("R7 sticky", 32'h0008_0000);

        // R8: write zeros, then all ones
        sts_wr_en = 1'b1; sts_wr_data = 32'h0000_0000;
        step();
        check("R8 zero write keeps flags", 32'hFFFF_FFFF);
        sts_wr_en = 1'b1; sts_wr_data = 32'hFFFF_FFFF;
        step();
        check("R8 ones write clears flags only", 32'hFFFF_FFFF);

        // R9: set and clear together
        sts_wr_en = 1'b1; sts_wr_data = 32'h000C_0000;
        ev_split_discard = 1'b1; ev_unexp_split = 1'b1;
        step();
        check("R9 set wins", 32'h000C_0000);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            cfg_wr_t0        = ($urandom % 4) == 0;
            cfg_ad           = 16'($urandom);
            sts_wr_en        = ($urandom % 3) == 0;
            sts_wr_data      = $urandom;
            ev_split_discard = ($urandom % 5) == 0;
            ev_unexp_split   = ($urandom % 5) == 0;
            ee_valid         = ($urandom % 50) == 0;
            ee_is64          = 1'($urandom);
            ee_fast133       = 1'($urandom);
            ee_max_read      = 1'($urandom);
            step();
            check_all();
            if (i == 1500) begin
                rst_n = 1'b0;
                step();
                model_reset();
                rst_n = 1'b1;
                check("R1 reset again", 32'hFFFF_FFFF);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule